// File: doc/BRIEF.md
# Shadow-Stack-Aware Leaf Translation Permission Checker

This block follows a page-table walk and decides whether one memory access may go ahead on the leaf entry that the walk returned. It covers both the single-stage and the first-stage case. Each request brings the valid, read, write, execute and user bits of the leaf, the kind of access, the effective privilege, the supervisor-user-access (SUM) and make-executable-readable (MXR) controls, the virtualization bit, two shadow-stack enables (machine level and hypervisor level) and a flag that says translation is off. One cycle later the block returns either a pass or a fault together with its exception cause.

The write-only leaf encoding (X=0, W=1, R=0) is taken as a shadow-stack page whenever the enable for the current virtualization level is set. Shadow-stack instructions may use only such pages. Ordinary stores and instruction fetches are kept off them. Ordinary loads may read them. A fault raised by a shadow-stack instruction is always reported with a store/AMO cause, and this holds for the pop-check, which only loads.

Top module: `sspte_check`

## Requirements
- R1: The result is registered. A request seen with `req_valid` high on a rising edge raises `rsp_valid` for exactly the next cycle. While `rsp_valid` is low, `rsp_fault` and `rsp_cause` are zero, and all three are zero after reset.
- R2: `acc_class` codes: 0 ordinary load, 1 ordinary store/AMO, 2 instruction fetch, 3 shadow-stack pop-check, 4 shadow-stack push, 5 shadow-stack swap; codes 6 and 7 behave as an ordinary load. `priv` codes: 0 user, 1 supervisor, 3 machine; code 2 behaves as supervisor. Cause values: instruction access fault 1, load access fault 5, store/AMO access fault 7, instruction page fault 12, load page fault 13, store/AMO page fault 15. A pass reports cause 0.
- R3: With translation active, a leaf with V=0, with XWR=110, with XWR=000, or with XWR=010 while the enable for the current level is 0 (`sse_m` when `virt`=0, `sse_h` when `virt`=1) raises the page fault of the access's own type. For a shadow-stack access that is 15.
- R4: A shadow-stack access to a read-only page (XWR=001) raises cause 15.
- R5: A shadow-stack access to XWR 011, 100, 101 or 111 raises cause 7.
- R6: An ordinary store to a shadow-stack page raises cause 7. A fetch from a shadow-stack page raises cause 1.
- R7: An ordinary load may read a shadow-stack page whatever the value of MXR, subject only to the user/SUM rule.
- R8: User/SUM rule: in user mode the leaf U bit must be 1. In supervisor mode a U=1 leaf always faults a fetch and faults any data access, shadow-stack accesses included, unless SUM=1. A violation raises the page fault of the access's type, which is 15 for shadow-stack accesses.
- R9: Ordinary permissions: a load needs R=1, or X=1 with MXR=1. A store needs W=1. A fetch needs X=1. A violation raises the page fault of the access's type.
- R10: Translation is off when `bare`=1 or `priv`=3. In that case the leaf is ignored and ordinary accesses pass. Every shadow-stack access below machine mode raises cause 7. A push or pop-check in machine mode passes.
- R11: A swap at machine privilege raises cause 7, whether or not translation is active.
- R12: Priority order: swap-at-machine, then the translation-off rule, then the valid/reserved check, then the shadow-stack page-type rules, then the user/SUM and R/W/X checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| acc_class | input | 3 | Access kind (R2 codes) |
| priv | input | 2 | Effective privilege (R2 codes) |
| pte_v | input | 1 | Leaf valid bit |
| pte_r | input | 1 | Leaf read bit |
| pte_w | input | 1 | Leaf write bit |
| pte_x | input | 1 | Leaf execute bit |
| pte_u | input | 1 | Leaf user bit |
| sum | input | 1 | Supervisor may touch user pages |
| mxr | input | 1 | Executable pages readable by loads |
| virt | input | 1 | Virtualization bit, selects the enable |
| sse_m | input | 1 | Machine-level shadow-stack enable |
| sse_h | input | 1 | Hypervisor-level shadow-stack enable |
| bare | input | 1 | Translation off |
| rsp_valid | output | 1 | Result strobe |
| rsp_fault | output | 1 | Access faults |
| rsp_cause | output | 5 | Exception cause, 0 on pass |

## Verification
The bench aims at the places where the shadow-stack rules and the ordinary rules overlap.

- **Pop-check causes.** It checks that a pop-check reports store causes (15 or 7). A design that followed the load-like nature of the access would report 13 or 5.
- **Read-only versus other non-shadow-stack pages.** It checks that a read-only page gives 15 while every other non-shadow-stack encoding gives 7. A design that mixed these up would send a copy-on-write case down the fatal path.
- **Enable selection.** It flips the enable for the wrong virtualization level. A design that selects the enable wrongly would treat encoding 010 as reserved when it is not, or the reverse.
- **Priority.** It puts an invalid leaf under an ordinary store to a page with encoding 010, and issues a swap in machine mode with translation off. A design with the wrong priority order would return the access fault or the pass instead.

// File: rtl/ssck_pkg.sv
package ssck_pkg;
  localparam int CAUSE_W = 5;

  localparam logic [2:0] ACC_LOAD   = 3'd0;
  localparam logic [2:0] ACC_STORE  = 3'd1;
  localparam logic [2:0] ACC_FETCH  = 3'd2;
  localparam logic [2:0] ACC_SSPOP  = 3'd3;
  localparam logic [2:0] ACC_SSPUSH = 3'd4;
  localparam logic [2:0] ACC_SSSWAP = 3'd5;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [CAUSE_W-1:0] C_NONE = 5'd0;
  localparam logic [CAUSE_W-1:0] C_IAF  = 5'd1;
  localparam logic [CAUSE_W-1:0] C_LAF  = 5'd5;
  localparam logic [CAUSE_W-1:0] C_SAF  = 5'd7;
  localparam logic [CAUSE_W-1:0] C_IPF  = 5'd12;
  localparam logic [CAUSE_W-1:0] C_LPF  = 5'd13;
  localparam logic [CAUSE_W-1:0] C_SPF  = 5'd15;

  localparam logic [2:0] XWR_SS   = 3'b010;
  localparam logic [2:0] XWR_RO   = 3'b001;
  localparam logic [2:0] XWR_WX   = 3'b110;
  localparam logic [2:0] XWR_NONE = 3'b000;

  typedef struct packed {
    logic ss;    // any shadow-stack instruction
    logic swap;  // shadow-stack swap
    logic ld;    // ordinary load
    logic st;    // ordinary store/AMO
    logic fx;    // instruction fetch
  } acc_flags_t;
endpackage

// File: rtl/ssck_decode.sv
module ssck_decode
  import ssck_pkg::*;
(
  input  logic [2:0]         acc_class,
  output acc_flags_t         flags,
  output logic [CAUSE_W-1:0] pf_cause,
  output logic [CAUSE_W-1:0] af_cause
);
  always_comb begin
    flags = '0;
    unique case (acc_class)
      ACC_STORE:  flags.st = 1'b1;
      ACC_FETCH:  flags.fx = 1'b1;
      ACC_SSPOP,
      ACC_SSPUSH: flags.ss = 1'b1;
      ACC_SSSWAP: begin
        flags.ss   = 1'b1;
        flags.swap = 1'b1;
      end
      default:    flags.ld = 1'b1;
    endcase
  end

  // Shadow-stack faults always take the store/AMO causes.
  always_comb begin
    if (flags.fx) begin
      pf_cause = C_IPF;
      af_cause = C_IAF;
    end else if (flags.ld) begin
      pf_cause = C_LPF;
      af_cause = C_LAF;
    end else begin
      pf_cause = C_SPF;
      af_cause = C_SAF;
    end
  end
endmodule

// File: rtl/ssck_rules.sv
module ssck_rules
  import ssck_pkg::*;
(
  input  acc_flags_t         flags,
  input  logic [CAUSE_W-1:0] pf_cause,
  input  logic [CAUSE_W-1:0] af_cause,
  input  logic [1:0]         priv,
  input  logic               pte_v,
  input  logic               pte_r,
  input  logic               pte_w,
  input  logic               pte_x,
  input  logic               pte_u,
  input  logic               sum,
  input  logic               mxr,
  input  logic               virt,
  input  logic               sse_m,
  input  logic               sse_h,
  input  logic               bare,
  output logic               fault,
  output logic [CAUSE_W-1:0] cause
);
  logic [2:0] xwr;
  logic       m_mode, no_xlate, ss_en, ss_pg, rsvd, user_ok, perm_ok;

  assign xwr      = {pte_x, pte_w, pte_r};
  assign m_mode   = (priv == PRIV_M);
  assign no_xlate = bare | m_mode;
  assign ss_en    = virt ? sse_h : sse_m;
  assign ss_pg    = (xwr == XWR_SS);

  assign rsvd = !pte_v || (xwr == XWR_WX) || (xwr == XWR_NONE) || (ss_pg && !ss_en);

  // U/SUM rule, applied to shadow-stack accesses as data accesses.
  always_comb begin
    if (priv == PRIV_U) user_ok = pte_u;
    else                user_ok = !pte_u || (!flags.fx && sum);
  end

  // Ordinary R/W/X check; shadow-stack pages are readable regardless of MXR.
  always_comb begin
    perm_ok = 1'b0;
    if (flags.ld) perm_ok = pte_r || (mxr && pte_x) || ss_pg;
    if (flags.st) perm_ok = pte_w;
    if (flags.fx) perm_ok = pte_x;
  end

  always_comb begin
    fault = 1'b0;
    cause = C_NONE;
    if (flags.swap && m_mode) begin
      fault = 1'b1;
      cause = C_SAF;
    end else if (no_xlate) begin
      if (flags.ss && !m_mode) begin
        fault = 1'b1;
        cause = C_SAF;
      end
    end else if (rsvd) begin
      fault = 1'b1;
      cause = pf_cause;
    end else if (flags.ss) begin
      if (!ss_pg) begin
        fault = 1'b1;
        cause = (xwr == XWR_RO) ? C_SPF : C_SAF;
      end else if (!user_ok) begin
        fault = 1'b1;
        cause = C_SPF;
      end
    end else if (ss_pg && (flags.st || flags.fx)) begin
      fault = 1'b1;
      cause = af_cause;
    end else if (!user_ok || !perm_ok) begin
      fault = 1'b1;
      cause = pf_cause;
    end
  end
endmodule

// File: rtl/sspte_check.sv
module sspte_check
  import ssck_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [2:0]         acc_class,
  input  logic [1:0]         priv,
  input  logic               pte_v,
  input  logic               pte_r,
  input  logic               pte_w,
  input  logic               pte_x,
  input  logic               pte_u,
  input  logic               sum,
  input  logic               mxr,
  input  logic               virt,
  input  logic               sse_m,
  input  logic               sse_h,
  input  logic               bare,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [CAUSE_W-1:0] rsp_cause
);
  acc_flags_t         flags;
  logic [CAUSE_W-1:0] pf_cause, af_cause, nxt_cause;
  logic               nxt_fault;

  ssck_decode u_dec (
    .acc_class (acc_class),
    .flags     (flags),
    .pf_cause  (pf_cause),
    .af_cause  (af_cause)
  );

  ssck_rules u_rules (
    .flags    (flags),
    .pf_cause (pf_cause),
    .af_cause (af_cause),
    .priv     (priv),
    .pte_v    (pte_v),
    .pte_r    (pte_r),
    .pte_w    (pte_w),
    .pte_x    (pte_x),
    .pte_u    (pte_u),
    .sum      (sum),
    .mxr      (mxr),
    .virt     (virt),
    .sse_m    (sse_m),
    .sse_h    (sse_h),
    .bare     (bare),
    .fault    (nxt_fault),
    .cause    (nxt_cause)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= C_NONE;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid & nxt_fault;
      rsp_cause <= req_valid ? nxt_cause : C_NONE;
    end
  end

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);  // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_fault && rsp_cause == C_NONE));  // R1
  AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_cause == C_IAF || rsp_cause == C_LAF || rsp_cause == C_SAF ||
                   rsp_cause == C_IPF || rsp_cause == C_LPF || rsp_cause == C_SPF));  // R2
  AST_SS_STORE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (rsp_fault && $past(req_valid && (acc_class == ACC_SSPOP || acc_class == ACC_SSPUSH ||
                                      acc_class == ACC_SSSWAP)))
      |-> (rsp_cause == C_SAF || rsp_cause == C_SPF));  // R4
  AST_SWAP_MACHINE: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid && acc_class == ACC_SSSWAP && priv == PRIV_M)
      |-> (rsp_fault && rsp_cause == C_SAF));  // R11
  AST_BARE_ORDINARY: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid && bare && (acc_class == ACC_LOAD || acc_class == ACC_STORE ||
                                acc_class == ACC_FETCH)) |-> !rsp_fault);  // R10
endmodule

// File: tb/sim_sspte_check.sv
`timescale 1ns/1ps
module sim_sspte_check;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] acc_class = 3'd0;
  logic [1:0] priv = 2'd0;
  logic       pte_v = 1'b0, pte_r = 1'b0, pte_w = 1'b0, pte_x = 1'b0, pte_u = 1'b0;
  logic       sum = 1'b0, mxr = 1'b0, virt = 1'b0, sse_m = 1'b0, sse_h = 1'b0, bare = 1'b0;
  logic       rsp_valid, rsp_fault;
  logic [4:0] rsp_cause;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sspte_check u0 (.*);

  // Expected {fault, cause} from the requirement text.
  function automatic logic [5:0] model();
    bit is_ss = (acc_class >= 3 && acc_class <= 5);
    bit is_st = (acc_class == 1);
    bit is_fx = (acc_class == 2);
    bit is_ld = !is_ss && !is_st && !is_fx;
    bit mach  = (priv == 2'd3);
    logic [2:0] xwr = {pte_x, pte_w, pte_r};
    bit en = virt ? sse_h : sse_m;
    logic [4:0] pf = is_fx ? 5'd12 : (is_ld ? 5'd13 : 5'd15);
    logic [4:0] af = is_fx ? 5'd1  : (is_ld ? 5'd5  : 5'd7);
    bit uok;
    if (acc_class == 5 && mach) return {1'b1, 5'd7};                  // R11
    if (bare || mach) return (is_ss && !mach) ? {1'b1, 5'd7} : 6'd0;  // R10
    if (!pte_v || xwr == 3'b110 || xwr == 3'b000 || (xwr == 3'b010 && !en))
      return {1'b1, pf};                                              // R3
    if (priv == 2'd0) uok = pte_u;
    else uok = !pte_u || (sum && !is_fx);
    if (is_ss) begin
      if (xwr == 3'b001) return {1'b1, 5'd15};                        // R4
      if (xwr != 3'b010) return {1'b1, 5'd7};                         // R5
      return uok ? 6'd0 : {1'b1, 5'd15};                              // R8
    end
    if (xwr == 3'b010 && !is_ld) return {1'b1, af};                   // R6
    if (!uok) return {1'b1, pf};
    if (is_ld && (pte_r || (mxr && pte_x) || xwr == 3'b010)) return 6'd0;  // R7, R9
    if (is_st && pte_w) return 6'd0;
    if (is_fx && pte_x) return 6'd0;
    return {1'b1, pf};
  endfunction

  task automatic check(string tag, logic [5:0] exp);
    n_run++;
    if (rsp_valid !== 1'b1 || {rsp_fault, rsp_cause} !== exp) begin
      n_fail++;
      $display("FAIL %s: valid=%0b fault=%0b cause=%0d expected fault=%0b cause=%0d",
               tag, rsp_valid, rsp_fault, rsp_cause, exp[5], exp[4:0]);
    end
  endtask

  // One request; compare with the hand value and with the model.
  task automatic go(string tag, logic ef, logic [4:0] ec, logic [2:0] a, logic [1:0] p,
                    logic [2:0] xwr, logic v, logic u, logic s, logic m,
                    logic vt, logic em, logic eh, logic b);
    @(negedge clk);
    acc_class = a; priv = p; {pte_x, pte_w, pte_r} = xwr; pte_v = v; pte_u = u;
    sum = s; mxr = m; virt = vt; sse_m = em; sse_h = eh; bare = b;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, {ef, ec});
    if (model() !== {ef, ec}) begin
      n_fail++;
      $display("FAIL %s: bench model=%0h expected %0h", tag, model(), {ef, ec});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_run++;
    if (rsp_valid !== 0 || rsp_fault !== 0 || rsp_cause !== 0) begin
      n_fail++;
      $display("FAIL R1 reset: %0b %0b %0d expected 0 0 0", rsp_valid, rsp_fault, rsp_cause);
    end
    rst = 1'b0;

    //  tag            f  cause a  p  xwr    v  u  s  m  vt em eh b
    go("R3 pop rsvd",  1, 15, 3, 1, 3'b010, 1, 0, 0, 0, 0, 0, 1, 0);
    go("R3 virt en",   1, 13, 0, 1, 3'b010, 1, 0, 0, 0, 1, 1, 0, 0);
    go("R3 v0 fetch",  1, 12, 2, 1, 3'b101, 0, 0, 0, 0, 0, 1, 1, 0);
    go("R3 wx store",  1, 15, 1, 1, 3'b110, 1, 0, 0, 0, 0, 1, 1, 0);
    go("R4 push ro",   1, 15, 4, 1, 3'b001, 1, 0, 0, 0, 0, 1, 1, 0);
    go("R4 pop ro",    1, 15, 3, 1, 3'b001, 1, 0, 0, 0, 0, 1, 1, 0);
    go("R5 pop rw",    1,  7, 3, 1, 3'b011, 1, 0, 0, 0, 0, 1, 1, 0);
    go("R5 push rwx",  1,  7, 4, 1, 3'b111, 1, 0, 0, 0, 0, 1, 1, 0);
    go("R5 swap xo",   1,  7, 5, 0, 3'b100, 1, 1, 0, 0, 0, 1, 1, 0);
    go("R6 store ss",  1,  7, 1, 1, 3'b010, 1, 0, 0, 0, 0, 1, 0, 0);
    go("R6 fetch ss",  1,  1, 2, 1, 3'b010, 1, 0, 0, 0, 1, 0, 1, 0);
    go("R7 load mxr0", 0,  0, 0, 1, 3'b010, 1, 0, 0, 0, 0, 1, 0, 0);
    go("R7 load mxr1", 0,  0, 0, 1, 3'b010, 1, 0, 0, 1, 0, 1, 0, 0);
    go("R8 push U u0", 1, 15, 4, 0, 3'b010, 1, 0, 0, 0, 0, 1, 1, 0);
    go("R8 pop nosum", 1, 15, 3, 1, 3'b010, 1, 1, 0, 0, 0, 1, 1, 0);
    go("R8 pop sum",   0,  0, 3, 1, 3'b010, 1, 1, 1, 0, 0, 1, 1, 0);
    go("R8 fetch sum", 1, 12, 2, 1, 3'b101, 1, 1, 1, 0, 0, 1, 1, 0);
    go("R8 load U ok", 0,  0, 0, 0, 3'b001, 1, 1, 0, 0, 0, 1, 1, 0);
    go("R9 load xo",   1, 13, 0, 1, 3'b100, 1, 0, 0, 0, 0, 1, 1, 0);
    go("R9 load mxr",  0,  0, 0, 1, 3'b100, 1, 0, 0, 1, 0, 1, 1, 0);
    go("R9 store ro",  1, 15, 1, 1, 3'b001, 1, 0, 0, 0, 0, 1, 1, 0);
    go("R9 fetch rw",  1, 12, 2, 1, 3'b011, 1, 0, 0, 0, 0, 1, 1, 0);
    go("R10 bare psh", 1,  7, 4, 1, 3'b010, 1, 0, 0, 0, 0, 1, 1, 1);
    go("R10 bare ld",  0,  0, 0, 0, 3'b000, 0, 0, 0, 0, 0, 0, 0, 1);
    go("R10 M pop",    0,  0, 3, 3, 3'b000, 0, 0, 0, 0, 0, 0, 0, 1);
    go("R11 swap M",   1,  7, 5, 3, 3'b010, 1, 0, 0, 0, 0, 1, 1, 0);
    go("R11 swap Mb",  1,  7, 5, 3, 3'b010, 1, 0, 0, 0, 0, 1, 1, 1);
    go("R12 v0 st ss", 1, 15, 1, 1, 3'b010, 0, 0, 0, 0, 0, 1, 1, 0);
    go("R12 swpM v0",  1,  7, 5, 3, 3'b001, 0, 0, 0, 0, 0, 0, 0, 0);
    go("R2 code6 ld",  1, 13, 6, 1, 3'b100, 1, 0, 0, 0, 0, 1, 1, 0);

    @(negedge clk);
    n_run++;
    if (rsp_valid !== 0 || rsp_fault !== 0 || rsp_cause !== 0) begin
      n_fail++;
      $display("FAIL R1 idle: %0b %0b %0d expected 0 0 0", rsp_valid, rsp_fault, rsp_cause);
    end

    // Constrained random mix, checked against the model (R12 ordering).
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      acc_class = 3'($urandom_range(0, 7));
      priv      = 2'($urandom_range(0, 3));
      {pte_x, pte_w, pte_r} = 3'($urandom_range(0, 7));
      pte_v = ($urandom_range(0, 7) != 0);
      pte_u = 1'($urandom); sum = 1'($urandom); mxr = 1'($urandom);
      virt  = 1'($urandom); sse_m = 1'($urandom); sse_h = 1'($urandom);
      bare  = ($urandom_range(0, 7) == 0);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R12 random", model());
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule